// File: doc/BRIEF.md
# Accelerator Host Command and Status Port

This block sits between a host CPU and a task-driven processing engine. The host issues each job as two word writes to one command port. The first word carries a command code and the requesting client's tag. The second word carries the address of the job's descriptor in memory. Once the pair is complete, the block places it in a command queue. The queue is offered to the engine as a single valid/ready transfer that presents the command word and the descriptor address together.

Results come back the other way. The engine hands in a completion code and a client tag, and the block stores them as one word in a status queue. The host pops that queue by reading a port register. The block checks each command as it arrives. A command that cannot be queued gets an error code, and so does a command with an unsupported code. These error codes travel through the same status queue as the engine's results.

The block has a status interrupt and a separate memory-error interrupt. It also holds configuration words, clock-enable bits for three engine domains, sticky memory-error capture registers, a soft flush and a fixed identifier. The command assembler is a three-state machine:

- ST_HEAD waits for a first word. On that word it moves to ST_BODY if the command is accepted, or to ST_DISCARD if it is rejected.
- ST_BODY waits for the descriptor word. On that word it queues the pair and returns to ST_HEAD.
- ST_DISCARD swallows the next port write and returns to ST_HEAD.
- A soft flush sends the machine from any state back to ST_HEAD.

Top module: `acc_host_if`

## Requirements
- R1: After reset both queues are empty, the task port is idle, both interrupts and all clock enables are low, and both fill-level registers read 0.
- R2: A first word at offset 0x114 carries the command code in bits 7:0 and the client tag in bits 15:8. The engine sees no task until the descriptor word (the next 0x114 write) has arrived. task_word then equals the first word's bits 15:0 and task_desc equals the second word.
- R3: If the command queue is full when a first word arrives, the pair is dropped and status {tag, 0xF0} is queued. The queue-full check takes precedence over the code check, and the next 0x114 write is discarded.
- R4: A first word whose code is 0 or greater than N_CODES is dropped and status {tag, 0xF1} is queued. The next 0x114 write is discarded.
- R5: An engine completion is accepted when done_valid and done_ready are both high, and it is queued as {done_client, done_code}. done_ready is low while the status queue is full or while a command error is being queued.
- R6: A read of offset 0x118 returns the oldest status word and removes it. When the status queue is empty, the read returns 0 and nothing changes.
- R7: Offset 0x11C reads the status queue occupancy in bits 3:0. Offset 0x110 reads the number of queued command pairs.
- R8: irq_sts rises in the cycle after any status push. It stays high until a write to offset 0x120 with bit 0 set. A write to 0x120 with bit 0 clear has no effect.
- R9: The three memory-error registers (0x128 local, 0x12C external, 0x130 secondary) OR in their error inputs every cycle. irq_err is high while any of them is nonzero. Any write to 0x124 clears all three.
- R10: Bits 2:0 at offset 0x148 are read/write and drive clk_en directly.
- R11: Offset 0x14C reads VERSION_ID in bits 15:0. The configuration words at 0x108, 0x10C and 0x150 are read/write and appear on their output ports.
- R12: A write with bit 0 set to offset 0x100 empties both queues, returns the assembler to ST_HEAD, clears irq_sts and sets bit 0 of 0x104. Any write to 0x104 clears that bit.
- R13: bus_rdata is registered. It changes only at the clock edge that samples bus_rd, and it then holds until the next read.
- R14: Tasks reach the engine in the order their pairs were completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| task_valid | output | 1 | A queued task is offered |
| task_ready | input | 1 | Engine takes the offered task |
| task_word | output | 16 | Client tag and command code of the task |
| task_desc | output | 32 | Descriptor address of the task |
| done_valid | input | 1 | Engine offers a completion |
| done_ready | output | 1 | Completion will be stored |
| done_code | input | 8 | Completion code |
| done_client | input | 8 | Client tag of the finished task |
| loc_err_in | input | 32 | Local memory error bits |
| ext_err_in | input | 32 | External memory error bits |
| sec_err_in | input | 32 | Secondary memory error bits |
| irq_sts | output | 1 | Status interrupt |
| irq_err | output | 1 | Memory-error interrupt |
| clk_en | output | 3 | Engine domain clock enables |
| mem_cfg | output | 32 | Memory interface configuration |
| mem_cfg2 | output | 32 | Secondary memory interface configuration |
| bs_cfg | output | 32 | Bitstream unit configuration |

## Verification
The bench builds the block with CMD_DEPTH=2, STS_DEPTH=4 and N_CODES=2. With these values, two command pairs fill the command queue, so the queue-full rejection and its precedence over the code check are reached within a few writes. Four completions fill the status queue, which exposes the done_ready back-pressure. With only two supported codes, code 3 falls just past the top of the supported range and code 0 sits below it, so both are rejected.

// File: rtl/acc_host_pkg.sv
package acc_host_pkg;
    localparam int WORD_W = 32;

    localparam logic [11:0] OFS_SOFTRST = 12'h100;
    localparam logic [11:0] OFS_RSTACK  = 12'h104;
    localparam logic [11:0] OFS_MEMCFG  = 12'h108;
    localparam logic [11:0] OFS_MEMCFG2 = 12'h10C;
    localparam logic [11:0] OFS_CMDLVL  = 12'h110;
    localparam logic [11:0] OFS_CMDPORT = 12'h114;
    localparam logic [11:0] OFS_STSPORT = 12'h118;
    localparam logic [11:0] OFS_STSLVL  = 12'h11C;
    localparam logic [11:0] OFS_IRQACK  = 12'h120;
    localparam logic [11:0] OFS_ERRACK  = 12'h124;
    localparam logic [11:0] OFS_ERR_LOC = 12'h128;
    localparam logic [11:0] OFS_ERR_EXT = 12'h12C;
    localparam logic [11:0] OFS_ERR_SEC = 12'h130;
    localparam logic [11:0] OFS_GATE    = 12'h148;
    localparam logic [11:0] OFS_VERSION = 12'h14C;
    localparam logic [11:0] OFS_BSCFG   = 12'h150;

    localparam logic [7:0] CODE_LIST_FULL = 8'hF0;
    localparam logic [7:0] CODE_BAD_CMD   = 8'hF1;

    typedef enum logic [1:0] {
        ST_HEAD    = 2'd0,
        ST_BODY    = 2'd1,
        ST_DISCARD = 2'd2
    } asm_state_t;
endpackage

// File: rtl/acc_sync_fifo.sv
module acc_sync_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !flush) mem[wr_ptr] <= din;
    end

    assign dout  = mem[rd_ptr];
    assign count = cnt;
    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/acc_cmd_asm.sv
module acc_cmd_asm
    import acc_host_pkg::*;
#(
    parameter int N_CODES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush,
    input  logic        wr,
    input  logic [31:0] wdata,
    input  logic        room,
    output logic        push,
    output logic [47:0] push_word,
    output logic        err_push,
    output logic [15:0] err_word
);
    asm_state_t state, state_nx;
    logic [15:0] head_q;
    logic [7:0]  err_code;
    logic        known;

    assign known = (wdata[7:0] != 8'h00) && (wdata[7:0] <= 8'(N_CODES));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     state <= ST_HEAD;
        else if (flush) state <= ST_HEAD;
        else            state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) head_q <= '0;
        else if (state == ST_HEAD && wr && room && known) head_q <= wdata[15:0];
    end

    always_comb begin
        state_nx = state;
        push     = 1'b0;
        err_push = 1'b0;
        err_code = 8'h00;
        unique case (state)
            ST_HEAD: if (wr) begin
                if (!room) begin
                    err_push = 1'b1;
                    err_code = CODE_LIST_FULL;
                    state_nx = ST_DISCARD;
                end else if (!known) begin
                    err_push = 1'b1;
                    err_code = CODE_BAD_CMD;
                    state_nx = ST_DISCARD;
                end else begin
                    state_nx = ST_BODY;
                end
            end
            ST_BODY: if (wr) begin
                push     = 1'b1;
                state_nx = ST_HEAD;
            end
            ST_DISCARD: if (wr) state_nx = ST_HEAD;
            default: state_nx = ST_HEAD;
        endcase
    end

    assign push_word = {head_q, wdata};
    assign err_word  = {wdata[15:8], err_code};

    assert_pair_completes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> $past(state_nx == ST_BODY));
endmodule

// File: rtl/acc_host_if.sv
module acc_host_if
    import acc_host_pkg::*;
#(
    parameter int          ADDR_W     = 12,
    parameter int          CMD_DEPTH  = 4,
    parameter int          STS_DEPTH  = 8,
    parameter int          N_CODES    = 2,
    parameter logic [15:0] VERSION_ID = 16'h0400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              task_valid,
    input  logic              task_ready,
    output logic [15:0]       task_word,
    output logic [31:0]       task_desc,
    input  logic              done_valid,
    output logic              done_ready,
    input  logic [7:0]        done_code,
    input  logic [7:0]        done_client,
    input  logic [31:0]       loc_err_in,
    input  logic [31:0]       ext_err_in,
    input  logic [31:0]       sec_err_in,
    output logic              irq_sts,
    output logic              irq_err,
    output logic [2:0]        clk_en,
    output logic [31:0]       mem_cfg,
    output logic [31:0]       mem_cfg2,
    output logic [31:0]       bs_cfg
);
    localparam int CCW = $clog2(CMD_DEPTH + 1);
    localparam int SCW = $clog2(STS_DEPTH + 1);

    function automatic logic wr_at(input logic [11:0] ofs);
        return bus_wr && (bus_addr == ADDR_W'(ofs));
    endfunction

    logic flush, irq_ack, err_ack;
    assign flush   = wr_at(OFS_SOFTRST) && bus_wdata[0];
    assign irq_ack = wr_at(OFS_IRQACK) && bus_wdata[0];
    assign err_ack = wr_at(OFS_ERRACK);

    logic        asm_push, asm_err;
    logic [47:0] asm_word;
    logic [15:0] asm_err_word;
    logic        cmd_full, cmd_empty;
    logic [CCW-1:0] cmd_count;
    logic [47:0] cmd_head;

    acc_cmd_asm #(.N_CODES(N_CODES)) u_asm (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .wr(wr_at(OFS_CMDPORT)), .wdata(bus_wdata), .room(!cmd_full),
        .push(asm_push), .push_word(asm_word),
        .err_push(asm_err), .err_word(asm_err_word)
    );

    acc_sync_fifo #(.W(48), .DEPTH(CMD_DEPTH)) u_cmd_q (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(asm_push), .din(asm_word),
        .pop(task_valid && task_ready), .dout(cmd_head),
        .count(cmd_count), .full(cmd_full), .empty(cmd_empty)
    );

    assign task_valid = !cmd_empty;
    assign task_word  = cmd_head[47:32];
    assign task_desc  = cmd_head[31:0];

    logic        sts_push, sts_pop, sts_full, sts_empty;
    logic [15:0] sts_din, sts_head;
    logic [SCW-1:0] sts_count;

    assign done_ready = !sts_full && !asm_err;
    assign sts_push   = (asm_err && !sts_full) || (done_valid && done_ready);
    assign sts_din    = asm_err ? asm_err_word : {done_client, done_code};
    assign sts_pop    = bus_rd && (bus_addr == ADDR_W'(OFS_STSPORT)) && !sts_empty;

    acc_sync_fifo #(.W(16), .DEPTH(STS_DEPTH)) u_sts_q (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(sts_push), .din(sts_din),
        .pop(sts_pop), .dout(sts_head),
        .count(sts_count), .full(sts_full), .empty(sts_empty)
    );

    logic [31:0] err_in [3];
    logic [31:0] err_q  [3];
    assign err_in[0] = loc_err_in;
    assign err_in[1] = ext_err_in;
    assign err_in[2] = sec_err_in;

    for (genvar i = 0; i < 3; i++) begin : g_err
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) err_q[i] <= '0;
            else        err_q[i] <= (err_ack ? 32'h0 : err_q[i]) | err_in[i];
        end
    end
    assign irq_err = (err_q[0] != 0) || (err_q[1] != 0) || (err_q[2] != 0);

    logic rst_ack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_sts  <= 1'b0;
            rst_ack  <= 1'b0;
            clk_en   <= '0;
            mem_cfg  <= '0;
            mem_cfg2 <= '0;
            bs_cfg   <= '0;
        end else begin
            if (flush)         irq_sts <= 1'b0;
            else if (sts_push) irq_sts <= 1'b1;
            else if (irq_ack)  irq_sts <= 1'b0;
            if (flush)                  rst_ack <= 1'b1;
            else if (wr_at(OFS_RSTACK)) rst_ack <= 1'b0;
            if (wr_at(OFS_GATE))    clk_en   <= bus_wdata[2:0];
            if (wr_at(OFS_MEMCFG))  mem_cfg  <= bus_wdata;
            if (wr_at(OFS_MEMCFG2)) mem_cfg2 <= bus_wdata;
            if (wr_at(OFS_BSCFG))   bs_cfg   <= bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_rdata <= '0;
        else if (bus_rd) begin
            case (bus_addr)
                ADDR_W'(OFS_RSTACK):  bus_rdata <= {31'h0, rst_ack};
                ADDR_W'(OFS_MEMCFG):  bus_rdata <= mem_cfg;
                ADDR_W'(OFS_MEMCFG2): bus_rdata <= mem_cfg2;
                ADDR_W'(OFS_CMDLVL):  bus_rdata <= 32'(cmd_count);
                ADDR_W'(OFS_STSPORT): bus_rdata <= sts_empty ? 32'h0 : {16'h0, sts_head};
                ADDR_W'(OFS_STSLVL):  bus_rdata <= {28'h0, 4'(sts_count)};
                ADDR_W'(OFS_ERR_LOC): bus_rdata <= err_q[0];
                ADDR_W'(OFS_ERR_EXT): bus_rdata <= err_q[1];
                ADDR_W'(OFS_ERR_SEC): bus_rdata <= err_q[2];
                ADDR_W'(OFS_GATE):    bus_rdata <= {29'h0, clk_en};
                ADDR_W'(OFS_VERSION): bus_rdata <= {16'h0, VERSION_ID};
                ADDR_W'(OFS_BSCFG):   bus_rdata <= bs_cfg;
                default:              bus_rdata <= 32'h0;
            endcase
        end
    end

    assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_sts && !irq_ack && !flush) |=> irq_sts);
    assert_irq_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_push && !flush) |=> irq_sts);
    assert_err_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_err_in != 0) |=> irq_err);
    assert_task_after_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(task_valid) |-> $past(asm_push));
    assert_done_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_ready && !flush) |=> !sts_empty);
    assert_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sts_count <= SCW'(STS_DEPTH));
endmodule

// File: tb/acc_host_if_bench.sv
module acc_host_if_bench;
    localparam int CD = 2;
    localparam int SD = 4;
    localparam int NC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic task_valid, task_ready = 1'b0;
    logic [15:0] task_word;
    logic [31:0] task_desc;
    logic done_valid = 1'b0, done_ready;
    logic [7:0] done_code = '0, done_client = '0;
    logic [31:0] loc_err_in = '0, ext_err_in = '0, sec_err_in = '0;
    logic irq_sts, irq_err;
    logic [2:0] clk_en;
    logic [31:0] mem_cfg, mem_cfg2, bs_cfg;

    always #4 clk = ~clk;

    acc_host_if #(.CMD_DEPTH(CD), .STS_DEPTH(SD), .N_CODES(NC)) u_acc_host_if (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .task_valid(task_valid),
        .task_ready(task_ready), .task_word(task_word), .task_desc(task_desc),
        .done_valid(done_valid), .done_ready(done_ready), .done_code(done_code),
        .done_client(done_client), .loc_err_in(loc_err_in), .ext_err_in(ext_err_in),
        .sec_err_in(sec_err_in), .irq_sts(irq_sts), .irq_err(irq_err), .clk_en(clk_en),
        .mem_cfg(mem_cfg), .mem_cfg2(mem_cfg2), .bs_cfg(bs_cfg)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model, advanced at every rising edge
    logic [47:0] mq_cmd[$];
    logic [15:0] mq_sts[$];
    int          m_st;
    logic [15:0] m_head;
    logic        m_irq;
    logic [31:0] m_err [3];
    logic [2:0]  m_gate;
    int csz, ssz;
    bit errp;
    logic [15:0] ew;

    function automatic bit head_err();
        int code;
        code = int'(bus_wdata[7:0]);
        return bus_wr && bus_addr == 12'h114 && m_st == 0 &&
               (mq_cmd.size() >= CD || code == 0 || code > NC);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mq_cmd.delete(); mq_sts.delete();
            m_st = 0; m_head = '0; m_irq = 1'b0; m_gate = '0;
            for (int i = 0; i < 3; i++) m_err[i] = '0;
        end else begin
            csz = mq_cmd.size();
            ssz = mq_sts.size();
            errp = 1'b0;
            ew = '0;
            if (bus_wr && bus_addr == 12'h100 && bus_wdata[0]) begin
                mq_cmd.delete(); mq_sts.delete();
                m_st = 0; m_irq = 1'b0;
            end else begin
                if (csz > 0 && task_ready) void'(mq_cmd.pop_front());
                if (bus_wr && bus_addr == 12'h114) begin
                    if (m_st == 0) begin
                        if (csz >= CD) begin
                            errp = 1'b1; ew = {bus_wdata[15:8], 8'hF0}; m_st = 2;
                        end else if (bus_wdata[7:0] == 0 || int'(bus_wdata[7:0]) > NC) begin
                            errp = 1'b1; ew = {bus_wdata[15:8], 8'hF1}; m_st = 2;
                        end else begin
                            m_head = bus_wdata[15:0]; m_st = 1;
                        end
                    end else if (m_st == 1) begin
                        mq_cmd.push_back({m_head, bus_wdata}); m_st = 0;
                    end else m_st = 0;
                end
                if (bus_rd && bus_addr == 12'h118 && ssz > 0) void'(mq_sts.pop_front());
                if (errp && ssz < SD) begin
                    mq_sts.push_back(ew); m_irq = 1'b1;
                end else if (!errp && done_valid && ssz < SD) begin
                    mq_sts.push_back({done_client, done_code}); m_irq = 1'b1;
                end else if (bus_wr && bus_addr == 12'h120 && bus_wdata[0]) m_irq = 1'b0;
            end
            m_err[0] = ((bus_wr && bus_addr == 12'h124) ? 32'h0 : m_err[0]) | loc_err_in;
            m_err[1] = ((bus_wr && bus_addr == 12'h124) ? 32'h0 : m_err[1]) | ext_err_in;
            m_err[2] = ((bus_wr && bus_addr == 12'h124) ? 32'h0 : m_err[2]) | sec_err_in;
            if (bus_wr && bus_addr == 12'h148) m_gate = bus_wdata[2:0];
        end
    end

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(task_valid == (mq_cmd.size() > 0), "R2 task_valid", 64'(task_valid), 64'(mq_cmd.size() > 0));
            if (mq_cmd.size() > 0)
                chk({task_word, task_desc} == mq_cmd[0], "R14 task head", {task_word, task_desc}, mq_cmd[0]);
            chk(irq_sts == m_irq, "R8 irq_sts", 64'(irq_sts), 64'(m_irq));
            chk(irq_err == ((m_err[0] | m_err[1] | m_err[2]) != 0), "R9 irq_err",
                64'(irq_err), 64'((m_err[0] | m_err[1] | m_err[2]) != 0));
            chk(clk_en == m_gate, "R10 clk_en", 64'(clk_en), 64'(m_gate));
            chk(done_ready == (mq_sts.size() < SD && !head_err()), "R5 done_ready",
                64'(done_ready), 64'(mq_sts.size() < SD && !head_err()));
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); #1;
        bus_rd = 1'b0;
        chk(bus_rdata == exp, tag, 64'(bus_rdata), 64'(exp));
    endtask

    task automatic done(input logic [7:0] c, input logic [7:0] cl);
        @(posedge clk); #1;
        done_valid = 1'b1; done_code = c; done_client = cl;
        @(posedge clk); #1;
        done_valid = 1'b0;
    endtask

    task automatic take_task();
        @(posedge clk); #1; task_ready = 1'b1;
        @(posedge clk); #1; task_ready = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog act=timeout exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk(!task_valid && !irq_sts && !irq_err && clk_en == 0, "R1 idle outputs",
            {task_valid, irq_sts, irq_err, clk_en}, 0);
        rd(12'h110, 0, "R1 cmd level");
        rd(12'h11C, 0, "R1 sts level");
        // R11 identifier and config words
        rd(12'h14C, 32'h0400, "R11 version");
        wr(12'h108, 32'h1234_5678);
        rd(12'h108, 32'h1234_5678, "R11 mem_cfg readback");
        chk(mem_cfg == 32'h1234_5678, "R11 mem_cfg port", mem_cfg, 32'h1234_5678);
        wr(12'h10C, 32'h0000_00C4);
        chk(mem_cfg2 == 32'hC4, "R11 mem_cfg2 port", mem_cfg2, 32'hC4);
        wr(12'h150, 32'h0003_F000);
        rd(12'h150, 32'h0003_F000, "R11 bs_cfg readback");
        // R10 clock enables, read-modify-write
        wr(12'h148, 32'h5);
        rd(12'h148, 32'h5, "R10 gate readback");
        wr(12'h148, 32'h5 | 32'h2);
        chk(clk_en == 3'h7, "R10 clk_en after rmw", clk_en, 7);
        // R2 pair assembly
        wr(12'h114, 32'h0301);
        chk(!task_valid, "R2 no task after head", task_valid, 0);
        wr(12'h114, 32'hA000_0000);
        chk(task_valid && task_word == 16'h0301 && task_desc == 32'hA000_0000, "R2 task contents",
            {task_valid, task_word, task_desc}, {1'b1, 16'h0301, 32'hA000_0000});
        rd(12'h110, 1, "R7 cmd level one");
        wr(12'h114, 32'h0502);
        wr(12'h114, 32'hB000_0010);
        rd(12'h110, 2, "R7 cmd level two");
        // R3 full queue, precedence over bad code
        wr(12'h114, 32'h0707);
        wr(12'h114, 32'h0000_DEAD);
        rd(12'h110, 2, "R3 pair dropped");
        chk(irq_sts, "R8 irq after error push", irq_sts, 1);
        rd(12'h11C, 1, "R7 sts level one");
        rd(12'h118, 32'h07F0, "R3 list-full status");
        // R6 empty pop
        rd(12'h118, 0, "R6 empty read zero");
        rd(12'h11C, 0, "R6 empty unchanged");
        // R8 acknowledge
        wr(12'h120, 32'h0);
        chk(irq_sts, "R8 ack bit0 clear ignored", irq_sts, 1);
        wr(12'h120, 32'h1);
        chk(!irq_sts, "R8 ack clears", irq_sts, 0);
        // R14 order
        take_task();
        chk(task_word == 16'h0502 && task_desc == 32'hB000_0010, "R14 second task",
            {task_word, task_desc}, {16'h0502, 32'hB000_0010});
        take_task();
        chk(!task_valid, "R14 drained", task_valid, 0);
        // R4 unknown codes
        wr(12'h114, 32'h0900);
        wr(12'h114, 32'h1111);
        chk(!task_valid, "R4 code zero dropped", task_valid, 0);
        rd(12'h118, 32'h09F1, "R4 code zero status");
        wr(12'h114, 32'h0403);
        wr(12'h114, 32'h2222);
        rd(12'h118, 32'h04F1, "R4 code above range status");
        wr(12'h114, 32'h0202);
        wr(12'h114, 32'h0000_00C0);
        chk(task_word == 16'h0202 && task_desc == 32'hC0, "R4 accepted after discard",
            {task_word, task_desc}, {16'h0202, 32'hC0});
        // R5 completions and back-pressure
        done(8'h00, 8'h01);
        done(8'h02, 8'h02);
        done(8'h04, 8'h03);
        done(8'h08, 8'h04);
        @(posedge clk); #1;
        done_valid = 1'b1; done_code = 8'h05; done_client = 8'h05;
        #1 chk(!done_ready, "R5 ready low when full", done_ready, 0);
        @(posedge clk); #1 done_valid = 1'b0;
        rd(12'h11C, 4, "R7 sts level full");
        rd(12'h118, 32'h0100, "R5 completion 1");
        rd(12'h118, 32'h0202, "R5 completion 2");
        rd(12'h118, 32'h0304, "R5 completion 3");
        rd(12'h118, 32'h0408, "R5 completion 4");
        // R12 soft flush
        wr(12'h114, 32'h0301);
        wr(12'h100, 32'h1);
        chk(!task_valid && !irq_sts, "R12 flush clears", {task_valid, irq_sts}, 0);
        rd(12'h110, 0, "R12 cmd queue empty");
        rd(12'h104, 1, "R12 ack set");
        wr(12'h104, 32'h0);
        rd(12'h104, 0, "R12 ack cleared");
        wr(12'h114, 32'h0102);
        wr(12'h114, 32'h0000_00E0);
        chk(task_word == 16'h0102 && task_desc == 32'hE0, "R12 assembler back at head",
            {task_word, task_desc}, {16'h0102, 32'hE0});
        // R9 memory errors
        @(posedge clk); #1 ext_err_in = 32'h40;
        @(posedge clk); #1 ext_err_in = 32'h0;
        chk(irq_err, "R9 irq_err raised", irq_err, 1);
        rd(12'h12C, 32'h40, "R9 external captured");
        rd(12'h128, 32'h0, "R9 local untouched");
        @(posedge clk); #1 loc_err_in = 32'h1;
        @(posedge clk); #1 loc_err_in = 32'h4;
        @(posedge clk); #1 loc_err_in = 32'h0; sec_err_in = 32'h2;
        @(posedge clk); #1 sec_err_in = 32'h0;
        rd(12'h128, 32'h5, "R9 local sticky or");
        rd(12'h130, 32'h2, "R9 secondary captured");
        wr(12'h124, 32'h0);
        chk(!irq_err, "R9 ack clears irq", irq_err, 0);
        rd(12'h12C, 32'h0, "R9 external cleared");
        // R13 registered read data
        @(posedge clk); #1 bus_rd = 1'b1; bus_addr = 12'h14C;
        chk(bus_rdata == 32'h0, "R13 holds before edge", bus_rdata, 0);
        @(posedge clk); #1 bus_rd = 1'b0;
        chk(bus_rdata == 32'h0400, "R13 updates at edge", bus_rdata, 32'h0400);
        @(posedge clk); #1;
        chk(bus_rdata == 32'h0400, "R13 holds without read", bus_rdata, 32'h0400);
        repeat (2) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule